// File: doc/BRIEF.md
# Serial Character Transmitter with Fractional Final Stop Bit

This block turns parallel characters into an asynchronous serial stream. A separate rate generator supplies a one-clock enable pulse sixteen times per bit period. Each character goes out in this order: a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Between characters the line rests high.

The final stop bit can be cut short in steps of one sixteenth of a bit. This lets a stream run slightly faster than the nominal rate, to keep pace with a receiver whose clock is a little fast. A 3-bit code selects the length. With two stop bits, only the second one is shortened. The first stop bit, and every part of a character, keeps full length.

A request input sends an idle character instead of data. An idle character keeps the line high for as many full bit periods as a data character would take. The fractional setting never changes its length. All format inputs may change at any time. The block captures them when it accepts a character, and the captured copy governs that character to its end.

Top module: `uft_tx`

## Requirements
- R1: After reset the line is high, busy is low and ready is high. Whenever busy is low, the line stays high and ready stays high.
- R2: An accepted character starts with a low start bit that lasts 16 enables. The data bits follow, least significant bit first, each lasting 16 enables. The number of data bits is 5 plus the value of the 2-bit length code (00 gives 5 bits, 11 gives 8 bits).
- R3: When parity is enabled, one parity bit of 16 enables follows the data bits. If the odd-select input is 0, the parity bit makes the count of ones in the data bits plus the parity bit even. If the odd-select input is 1, it makes that count odd.
- R4: The final stop bit is high and lasts 9 plus the 3-bit fraction code in enables. Code 111 gives 16 enables and code 000 gives 9.
- R5: With the two-stop select set to 1, a full 16-enable stop bit comes first. Only the second stop bit is shortened as R4 describes.
- R6: The format inputs and the fraction code are captured on the clock that accepts a character. Changing them while that character is in flight has no effect on it.
- R7: Ready is high only in the idle state, or in the clock whose enable ends the final stop bit. A character accepted in that clock starts its start bit at once, with no gap.
- R8: When the block is idle, a request with no valid data sends an idle character. The line stays high for 16 enables times (1 + data bits + parity bit + stop bits). The fraction code does not shorten it. Valid data takes priority over the request when both are present in the same cycle.
- R9: Busy goes high on the clock after an acceptance. It stays high through the last enable of the character.
- R10: While busy, the line changes only on a clock edge that follows a cycle with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| txData | input | 8 | Character to send |
| txValid | input | 1 | Character offered |
| txReady | output | 1 | Character accepted on this clock when txValid is high |
| charLen | input | 2 | Data bit count minus 5 |
| parityEn | input | 1 | Adds a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| twoStop | input | 1 | 1 selects two stop bits |
| fracStop | input | 3 | Length code of the final stop bit |
| idleReq | input | 1 | Request for an idle character |
| txLine | output | 1 | Serial output, high at rest |
| busy | output | 1 | A character is in progress |

## Verification
The line changes on the clock after acceptance, and after that only on the clock after an enable. The bench therefore records the line once per enable, partway through the clock low phase, while busy is high. It compares the record enable by enable with a waveform built from the requirements. Under this scheme a start bit fills exactly 16 samples and a shortened stop bit fills 9 plus its code. A second character held valid must follow the first with no extra sample between them.

The handshake is due in the same clock that ready is seen high. The bench therefore checks ready just after the falling edge and releases valid after the next rising edge.

// File: rtl/uft_pkg.sv
package uft_pkg;
  parameter int UFT_DATA_W = 8;
  parameter int UFT_TICKS  = 16;
  parameter int UFT_FRAC_W = 3;
  parameter int UFT_LEN_W  = 2;
  parameter int UFT_MIN_BITS = 5;

  localparam int CNT_W  = $clog2(UFT_TICKS);
  localparam int BITS_W = $clog2(UFT_DATA_W + 5);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOPL, ST_FILL
  } txState_t;

  typedef enum logic [1:0] {
    LINE_MARK, LINE_SPACE, LINE_DATA, LINE_PAR
  } lineSel_t;

  typedef struct packed {
    logic     loadChar;
    logic     loadIdle;
    logic     shiftBit;
    lineSel_t lineSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [BITS_W-1:0]     dataBits;
    logic                  parityEn;
    logic                  parityOdd;
    logic                  twoStop;
    logic [UFT_FRAC_W-1:0] frac;
  } txCfg_t;
endpackage

// File: rtl/uft_dpath.sv
module uft_dpath
  import uft_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrobe_t           strobe,
  input  logic [UFT_DATA_W-1:0] txData,
  input  logic [UFT_LEN_W-1:0]  charLen,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  input  logic                  twoStop,
  input  logic [UFT_FRAC_W-1:0] fracStop,
  output txCfg_t                cfg,
  output logic                  txLine
);
  logic [UFT_DATA_W-1:0] shiftReg;
  logic [UFT_DATA_W-1:0] dataMask;
  logic [BITS_W-1:0]     bitsNow;
  logic                  parBit;
  logic                  parNext;

  assign bitsNow = BITS_W'(UFT_MIN_BITS) + BITS_W'(charLen);

  // Mask selects only the bits that belong to the chosen length.
  generate
    for (genvar i = 0; i < UFT_DATA_W; i++) begin : g_mask
      assign dataMask[i] = (BITS_W'(i) < bitsNow);
    end
  endgenerate

  assign parNext = (^(txData & dataMask)) ^ parityOdd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg      <= '1;
      parBit        <= 1'b1;
      cfg.dataBits  <= BITS_W'(UFT_DATA_W);
      cfg.parityEn  <= 1'b0;
      cfg.parityOdd <= 1'b0;
      cfg.twoStop   <= 1'b0;
      cfg.frac      <= '1;
    end else begin
      if (strobe.loadChar || strobe.loadIdle) begin
        cfg.dataBits  <= bitsNow;
        cfg.parityEn  <= parityEn;
        cfg.parityOdd <= parityOdd;
        cfg.twoStop   <= twoStop;
        cfg.frac      <= fracStop;
      end
      if (strobe.loadChar) begin
        shiftReg <= txData;
        parBit   <= parNext;
      end else if (strobe.loadIdle) begin
        shiftReg <= '1;
        parBit   <= 1'b1;
      end else if (strobe.shiftBit) begin
        shiftReg <= {1'b1, shiftReg[UFT_DATA_W-1:1]};
      end
    end
  end

  always_comb begin
    unique case (strobe.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_DATA:  txLine = shiftReg[0];
      LINE_PAR:   txLine = parBit;
      default:    txLine = 1'b1;
    endcase
  end
endmodule

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        txValid,
  input  logic        idleReq,
  input  txCfg_t      cfg,
  output ctrlStrobe_t strobe,
  output logic        txReady,
  output logic        busy
);
  localparam int SHORTEST = UFT_TICKS - (2**UFT_FRAC_W - 1);

  txState_t          state, stateNext;
  logic [CNT_W-1:0]  tickCnt, tickNext;
  logic [BITS_W-1:0] bitCnt, bitNext;
  logic [CNT_W:0]    lastTicks;
  logic [BITS_W-1:0] fillBits;
  logic              bitEnd, stopEnd, finalEnd, accept, startIdle;

  assign lastTicks = (CNT_W+1)'(SHORTEST) + (CNT_W+1)'(cfg.frac);
  assign fillBits  = BITS_W'(1) + cfg.dataBits + BITS_W'(cfg.parityEn)
                   + (cfg.twoStop ? BITS_W'(2) : BITS_W'(1));

  assign bitEnd   = tick16 && (tickCnt == CNT_W'(UFT_TICKS - 1));
  assign stopEnd  = tick16 && ({1'b0, tickCnt} == lastTicks - 1'b1);
  assign finalEnd = ((state == ST_STOPL) && stopEnd) ||
                    ((state == ST_FILL) && bitEnd && (bitCnt == fillBits - 1'b1));

  assign txReady   = (state == ST_IDLE) || finalEnd;
  assign accept    = txValid && txReady;
  assign startIdle = (state == ST_IDLE) && idleReq && !txValid;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    tickNext  = tickCnt;
    bitNext   = bitCnt;
    strobe    = '{loadChar: accept, loadIdle: startIdle, shiftBit: 1'b0,
                  lineSel: LINE_MARK};

    unique case (state)
      ST_START: strobe.lineSel = LINE_SPACE;
      ST_DATA:  strobe.lineSel = LINE_DATA;
      ST_PAR:   strobe.lineSel = LINE_PAR;
      default:  strobe.lineSel = LINE_MARK;
    endcase

    if (tick16 && state != ST_IDLE) tickNext = tickCnt + 1'b1;

    unique case (state)
      ST_IDLE: begin
        tickNext = '0;
        bitNext  = '0;
        if (accept)         stateNext = ST_START;
        else if (startIdle) stateNext = ST_FILL;
      end
      ST_START: if (bitEnd) begin
        tickNext  = '0;
        bitNext   = '0;
        stateNext = ST_DATA;
      end
      ST_DATA: if (bitEnd) begin
        tickNext        = '0;
        strobe.shiftBit = 1'b1;
        if (bitCnt == cfg.dataBits - 1'b1) begin
          bitNext = '0;
          if (cfg.parityEn)     stateNext = ST_PAR;
          else if (cfg.twoStop) stateNext = ST_STOP1;
          else                  stateNext = ST_STOPL;
        end else begin
          bitNext = bitCnt + 1'b1;
        end
      end
      ST_PAR: if (bitEnd) begin
        tickNext  = '0;
        stateNext = cfg.twoStop ? ST_STOP1 : ST_STOPL;
      end
      ST_STOP1: if (bitEnd) begin
        tickNext  = '0;
        stateNext = ST_STOPL;
      end
      ST_STOPL: if (stopEnd) begin
        tickNext  = '0;
        stateNext = accept ? ST_START : ST_IDLE;
      end
      ST_FILL: if (bitEnd) begin
        tickNext = '0;
        if (finalEnd) begin
          bitNext   = '0;
          stateNext = accept ? ST_START : ST_IDLE;
        end else begin
          bitNext = bitCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickNext;
      bitCnt  <= bitNext;
    end
  end
endmodule

// File: rtl/uft_tx.sv
module uft_tx
  import uft_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick16,
  input  logic [UFT_DATA_W-1:0] txData,
  input  logic                  txValid,
  output logic                  txReady,
  input  logic [UFT_LEN_W-1:0]  charLen,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  input  logic                  twoStop,
  input  logic [UFT_FRAC_W-1:0] fracStop,
  input  logic                  idleReq,
  output logic                  txLine,
  output logic                  busy
);
  ctrlStrobe_t strobe;
  txCfg_t      cfg;

  uft_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .txValid(txValid),
    .idleReq(idleReq), .cfg(cfg), .strobe(strobe), .txReady(txReady),
    .busy(busy)
  );

  uft_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .txData(txData),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .fracStop(fracStop), .cfg(cfg), .txLine(txLine)
  );
endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic txValid,
  input logic txReady,
  input logic txLine,
  input logic busy
);
  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txLine && txReady));

  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txReady) |-> tick16);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |=> busy);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |=> !txLine);

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick16)) |-> $stable(txLine));
endmodule

bind uft_tx uft_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .txValid(txValid),
  .txReady(txReady), .txLine(txLine), .busy(busy)
);

// File: tb/tb_uft_tx.sv
module tb_uft_tx;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick16 = 0;
  logic [7:0] txData = 0;
  logic       txValid = 0;
  logic       txReady;
  logic [1:0] charLen = 2'b11;
  logic       parityEn = 0, parityOdd = 0, twoStop = 0;
  logic [2:0] fracStop = 3'b111;
  logic       idleReq = 0;
  logic       txLine, busy;

  int checks = 0, fails = 0;
  bit done = 0;
  bit rec [0:4095];
  bit expv [0:4095];
  int recN = 0, expN = 0;
  bit recOn = 0;
  int tickPhase = 0;

  uft_tx dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tickPhase = (tickPhase == 2) ? 0 : tickPhase + 1;
    tick16 = (tickPhase == 0);
  end

  always @(negedge clk) begin
    #2;
    if (recOn && tick16 && busy) begin
      if (recN < 4096) rec[recN] = txLine;
      recN++;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addBits(bit v, int n);
    for (int i = 0; i < n; i++) begin
      expv[expN] = v;
      expN++;
    end
  endtask

  task automatic expChar(logic [7:0] d, int len, bit pe, bit po, bit two, int frac);
    bit p = po;
    addBits(0, 16);
    for (int i = 0; i < len; i++) begin
      addBits(d[i], 16);
      p ^= d[i];
    end
    if (pe) addBits(p, 16);
    if (two) addBits(1, 16);
    addBits(1, 9 + frac);
  endtask

  task automatic startRec();
    recN = 0; expN = 0; recOn = 1;
  endtask

  task automatic pushChar(logic [7:0] d);
    @(negedge clk); txData = d; txValid = 1; #1;
    while (!txReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; txValid = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
    repeat (4) @(negedge clk);
    recOn = 0;
  endtask

  task automatic compare(string req);
    int bad = -1;
    for (int i = 0; i < expN && i < 4096; i++)
      if (bad < 0 && rec[i] !== expv[i]) bad = i;
    checks++;
    if (recN != expN || bad >= 0) begin
      fails++;
      $display("FAIL %s actual=len %0d mismatch at %0d expected=len %0d", req, recN, bad, expN);
    end
  endtask

  task automatic setFmt(int len, bit pe, bit po, bit two, int frac);
    charLen = 2'(len - 5); parityEn = pe; parityOdd = po; twoStop = two; fracStop = 3'(frac);
  endtask

  task automatic tReset();
    #1;
    check("R1 line", txLine, 1);
    check("R1 busy", busy, 0);
    check("R1 ready", txReady, 1);
  endtask

  task automatic tPlain();
    setFmt(8, 0, 0, 0, 7); startRec();
    pushChar(8'hA6);
    expChar(8'hA6, 8, 0, 0, 0, 7);
    @(negedge clk); #1;
    check("R7 ready low mid char", txReady, 0);
    check("R9 busy mid char", busy, 1);
    waitIdle(); compare("R2 8N1 frame");
  endtask

  task automatic tParity();
    setFmt(5, 1, 0, 0, 7); startRec();
    pushChar(8'hF3); expChar(8'hF3, 5, 1, 0, 0, 7);
    waitIdle(); compare("R3 even parity 5 bits");
    setFmt(7, 1, 1, 0, 7); startRec();
    pushChar(8'h2D); expChar(8'h2D, 7, 1, 1, 0, 7);
    waitIdle(); compare("R3 odd parity 7 bits");
  endtask

  task automatic tFracSweep();
    for (int f = 0; f < 8; f++) begin
      setFmt(8, 0, 0, 0, f); startRec();
      pushChar(8'h55); expChar(8'h55, 8, 0, 0, 0, f);
      waitIdle(); compare($sformatf("R4 fraction code %0d", f));
    end
  endtask

  task automatic tTwoStop();
    setFmt(6, 1, 0, 1, 0); startRec();
    pushChar(8'h15); expChar(8'h15, 6, 1, 0, 1, 0);
    waitIdle(); compare("R5 two stop short second");
  endtask

  task automatic tMidChange();
    setFmt(8, 0, 0, 0, 0); startRec();
    pushChar(8'h3C);
    expChar(8'h3C, 8, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    setFmt(6, 1, 1, 1, 7);
    pushChar(8'h0A);
    expChar(8'h0A, 6, 1, 1, 1, 7);
    waitIdle(); compare("R6 R7 mid change and back to back");
  endtask

  task automatic tIdle();
    setFmt(8, 0, 0, 0, 0); startRec();
    @(negedge clk); idleReq = 1; @(posedge clk); #1; idleReq = 0;
    addBits(1, 16 * 10);
    waitIdle(); compare("R8 idle char full length");
    setFmt(7, 1, 0, 1, 0); startRec();
    @(negedge clk); idleReq = 1; @(posedge clk); #1; idleReq = 0;
    addBits(1, 16 * 11);
    waitIdle(); compare("R8 idle char with parity two stop");
    setFmt(8, 0, 0, 0, 7); startRec();
    @(negedge clk); idleReq = 1; txData = 8'h81; txValid = 1;
    @(posedge clk); #1; idleReq = 0; txValid = 0;
    expChar(8'h81, 8, 0, 0, 0, 7);
    waitIdle(); compare("R8 data wins over idle request");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    tPlain();
    tParity();
    tFracSweep();
    tTwoStop();
    tMidChange();
    tIdle();
    #1; check("R1 idle after run", {txLine, busy}, 2'b10);
    finishRun();
  end
endmodule